// File: doc/BRIEF.md
# Handshaked Shift-Register Byte Transfer Engine

This block moves bytes between a host and a small peripheral controller through one 8-bit shift register and three active-low handshake wires. The host drives a transfer-in-progress line and an acknowledge line. The block drives a transfer-request line back to the host. A direction input selects the transfer direction. In host-to-device mode, every handshake edge captures the shift register into an outbound packet buffer. In device-to-host mode, every handshake edge loads the next byte of an inbound packet into the shift register.

When the host releases transfer-in-progress, the block closes the transfer. If any outbound bytes were captured, it pulses a packet-received strobe and reports the packet length. The device side fills the inbound buffer through a load port. While no transfer is running, the block asserts transfer-request for as long as inbound bytes remain unread. If the host toggles acknowledge while idle, transfer-request follows the acknowledge level, which gives the two sides a simple way to synchronise. A shift flag marks every event that the host should service, and reading the shift register clears it.

Top module: `hs_byte_xfer`

## Requirements
- R1: After reset, `req_n` is 1, `sflag` is 0, `sr_q` is 0 and `pkt_rx` is 0.
- R2: While `xip_n` is low and `dir_out` is 1, each change of the synchronised `ack_n` or `xip_n` stores `sr_q` into the next outbound slot and sets `sflag`. Slots are filled from index 0 upward and can be read through `out_idx`/`out_byte`.
- R3: Once OUT_DEPTH bytes have been captured, further handshake edges in host-to-device mode store nothing and leave `sflag` unchanged.
- R4: While `xip_n` is low and `dir_out` is 0, each handshake change loads the next unread inbound byte into `sr_q` and sets `sflag`. If no unread byte remains, the change has no effect.
- R5: When the last inbound byte has been loaded, `req_n` goes to 1 and stays there until new unread data exists.
- R6: While `xip_n` is high and no idle acknowledge toggle occurs, `req_n` is driven to 0 whenever unread inbound bytes remain.
- R7: While `xip_n` is high and was high on the previous sample, each toggle of `ack_n` sets `req_n` equal to the new `ack_n` level and sets `sflag`.
- R8: On the first sample after `xip_n` rises, `sflag` is set. If the outbound count is non-zero, `pkt_rx` pulses for one cycle with `pkt_len` equal to the count. The count then returns to zero.
- R9: `sr_q` always shows the shift register. A cycle with `sr_rd` high clears `sflag`, unless a flag-setting event happens in the same cycle, in which case the set wins. Reading does not change `sr_q`.
- R10: `ld_wr` with `ld_first` high writes the byte at inbound index 0, sets the inbound length to 1 and resets the read position. `ld_wr` with `ld_first` low appends a byte. Appends beyond IN_DEPTH bytes are dropped.
- R11: `sr_wr` loads `sr_wdata` into the shift register unless an inbound byte is loaded in the same cycle.
- R12: Handshake inputs pass through two synchronising flops. A change applied before a rising edge takes effect at the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xip_n | input | 1 | Transfer in progress from host, active low |
| ack_n | input | 1 | Acknowledge from host, active low |
| req_n | output | 1 | Transfer request to host, active low |
| dir_out | input | 1 | 1 = host-to-device, 0 = device-to-host |
| sr_wr | input | 1 | Host write strobe for the shift register |
| sr_wdata | input | 8 | Host write data |
| sr_rd | input | 1 | Host read strobe, clears the shift flag |
| sr_q | output | 8 | Shift register value |
| sflag | output | 1 | Shift event flag |
| ld_wr | input | 1 | Inbound buffer write strobe |
| ld_first | input | 1 | Marks the first byte of a new inbound packet |
| ld_byte | input | 8 | Inbound byte |
| pkt_rx | output | 1 | One-cycle pulse: outbound packet complete |
| pkt_len | output | $clog2(OUT_DEPTH+1) | Length of the completed outbound packet |
| out_idx | input | $clog2(OUT_DEPTH) | Outbound buffer read index |
| out_byte | output | 8 | Outbound buffer byte at `out_idx` |

## Verification
The bench builds the block with OUT_DEPTH = 4 and IN_DEPTH = 6. With these small depths, outbound overflow is reached after a few acknowledge toggles, and the inbound append limit is reached with a seven-byte load. The exact three-edge synchroniser latency, the idle acknowledge echo on the request line, and two consecutive packets of different lengths are also exercised. Each completed packet is checked byte by byte against what the driver queued.

// File: rtl/hs_byte_xfer.sv
module hs_byte_xfer #(
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 128,
  localparam int OCW = $clog2(OUT_DEPTH + 1),
  localparam int OAW = $clog2(OUT_DEPTH),
  localparam int ICW = $clog2(IN_DEPTH + 1),
  localparam int IAW = $clog2(IN_DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           xip_n,
  input  logic           ack_n,
  output logic           req_n,
  input  logic           dir_out,
  input  logic           sr_wr,
  input  logic [7:0]     sr_wdata,
  input  logic           sr_rd,
  output logic [7:0]     sr_q,
  output logic           sflag,
  input  logic           ld_wr,
  input  logic           ld_first,
  input  logic [7:0]     ld_byte,
  output logic           pkt_rx,
  output logic [OCW-1:0] pkt_len,
  input  logic [OAW-1:0] out_idx,
  output logic [7:0]     out_byte
);

  logic [1:0] xip_sy, ack_sy;
  logic xip_p, ack_p;
  logic [OCW-1:0] out_cnt;
  logic [ICW-1:0] in_len, in_idx;
  logic [7:0] out_mem [OUT_DEPTH];
  logic [7:0] in_mem  [IN_DEPTH];

  wire xip_s    = xip_sy[1];
  wire ack_s    = ack_sy[1];
  wire ack_tog  = ack_s ^ ack_p;
  wire hs_chg   = (xip_s ^ xip_p) | ack_tog;
  wire active   = ~xip_s;
  wire in_avail = in_idx < in_len;
  wire out_room = out_cnt < OCW'(OUT_DEPTH);
  wire cap_en   = active & dir_out & hs_chg & out_room;
  wire feed_en  = active & ~dir_out & hs_chg & in_avail;
  wire sync_tog = ~active & xip_p & ack_tog;
  wire xfer_end = ~active & ~xip_p;
  wire set_flag = cap_en | feed_en | sync_tog | xfer_end;
  wire ld_ok    = ld_wr & (ld_first | (in_len < ICW'(IN_DEPTH)));
  wire [IAW-1:0] ld_ptr = ld_first ? '0 : in_len[IAW-1:0];

  assign out_byte = out_mem[out_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xip_sy <= 2'b11;
      ack_sy <= 2'b11;
      xip_p  <= 1'b1;
      ack_p  <= 1'b1;
    end else begin
      xip_sy <= {xip_sy[0], xip_n};
      ack_sy <= {ack_sy[0], ack_n};
      xip_p  <= xip_s;
      ack_p  <= ack_s;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) out_mem[out_cnt[OAW-1:0]] <= sr_q;
    if (ld_ok)  in_mem[ld_ptr] <= ld_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      sflag   <= 1'b0;
      req_n   <= 1'b1;
      out_cnt <= '0;
      in_len  <= '0;
      in_idx  <= '0;
      pkt_rx  <= 1'b0;
      pkt_len <= '0;
    end else begin
      if (feed_en)    sr_q <= in_mem[in_idx[IAW-1:0]];
      else if (sr_wr) sr_q <= sr_wdata;

      if (set_flag)   sflag <= 1'b1;
      else if (sr_rd) sflag <= 1'b0;

      if (feed_en) begin
        if ((in_idx + ICW'(1)) >= in_len) req_n <= 1'b1;
      end else if (sync_tog) begin
        req_n <= ack_s;
      end else if (~active && in_avail) begin
        req_n <= 1'b0;
      end

      if (xfer_end)    out_cnt <= '0;
      else if (cap_en) out_cnt <= out_cnt + OCW'(1);

      pkt_rx <= xfer_end & (out_cnt != '0);
      if (xfer_end && out_cnt != '0) pkt_len <= out_cnt;

      if (ld_wr && ld_first) begin
        in_len <= ICW'(1);
        in_idx <= '0;
      end else begin
        if (ld_ok)   in_len <= in_len + ICW'(1);
        if (feed_en) in_idx <= in_idx + ICW'(1);
      end
    end
  end

endmodule

// File: rtl/hs_byte_xfer_chk.sv
module hs_byte_xfer_chk #(
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 128,
  localparam int OCW = $clog2(OUT_DEPTH + 1),
  localparam int ICW = $clog2(IN_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pkt_rx,
  input logic [OCW-1:0] pkt_len,
  input logic           sflag,
  input logic [OCW-1:0] out_cnt,
  input logic [ICW-1:0] in_len,
  input logic [ICW-1:0] in_idx
);

  p_pkt_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rx |=> !pkt_rx);

  p_pkt_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rx |-> (pkt_len != '0 && pkt_len <= OCW'(OUT_DEPTH)));

  p_pkt_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rx |-> sflag);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= OCW'(OUT_DEPTH));

  p_read_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_idx <= in_len && in_len <= ICW'(IN_DEPTH));

endmodule

bind hs_byte_xfer hs_byte_xfer_chk #(.OUT_DEPTH(OUT_DEPTH), .IN_DEPTH(IN_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_rx(pkt_rx), .pkt_len(pkt_len), .sflag(sflag),
  .out_cnt(out_cnt), .in_len(in_len), .in_idx(in_idx)
);

// File: tb/hs_byte_xfer_bench.sv
module hs_byte_xfer_bench;
  localparam int TOUT = 4;
  localparam int TIN  = 6;

  logic clk = 0, rst_n = 0;
  logic xip_n = 1, ack_n = 1, dir_out = 0;
  logic sr_wr = 0, sr_rd = 0, ld_wr = 0, ld_first = 0;
  logic [7:0] sr_wdata = 0, ld_byte = 0;
  logic [1:0] out_idx = 0;
  logic req_n, sflag, pkt_rx;
  logic [7:0] sr_q, out_byte;
  logic [2:0] pkt_len;

  int n_chk = 0, n_bad = 0;
  int exp_len_q[$];
  logic [7:0] exp_byte_q[$];
  logic [7:0] din [7];

  hs_byte_xfer #(.OUT_DEPTH(TOUT), .IN_DEPTH(TIN)) u_hs_byte_xfer (
    .clk(clk), .rst_n(rst_n), .xip_n(xip_n), .ack_n(ack_n), .req_n(req_n),
    .dir_out(dir_out), .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_rd(sr_rd),
    .sr_q(sr_q), .sflag(sflag), .ld_wr(ld_wr), .ld_first(ld_first),
    .ld_byte(ld_byte), .pkt_rx(pkt_rx), .pkt_len(pkt_len),
    .out_idx(out_idx), .out_byte(out_byte));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] b);
    sr_wr = 1; sr_wdata = b; wait_n(1); sr_wr = 0;
  endtask

  task automatic host_read();
    sr_rd = 1; wait_n(1); sr_rd = 0;
  endtask

  task automatic load(input logic [7:0] b, input bit first);
    ld_wr = 1; ld_first = first; ld_byte = b; wait_n(1); ld_wr = 0; ld_first = 0;
  endtask

  always @(negedge clk) begin
    if (pkt_rx) begin
      if (exp_len_q.size() == 0) begin
        chk(0, "R8 unexpected packet", int'(pkt_len), 0);
      end else begin
        int l;
        l = exp_len_q.pop_front();
        chk(pkt_len == 3'(l), "R8 packet length", int'(pkt_len), l);
        for (int i = 0; i < l; i++) begin
          logic [7:0] eb;
          out_idx = 2'(i);
          #1;
          eb = exp_byte_q.pop_front();
          chk(out_byte == eb, "R2 captured byte", int'(out_byte), int'(eb));
        end
      end
    end
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    chk(req_n == 1, "R1 req_n", req_n, 1);
    chk(sflag == 0, "R1 sflag", sflag, 0);
    chk(sr_q == 0, "R1 sr_q", sr_q, 0);
    chk(pkt_rx == 0, "R1 pkt_rx", pkt_rx, 0);

    host_write(8'hA5);
    chk(sr_q == 8'hA5, "R11 host write", sr_q, 8'hA5);

    load(8'h11, 1); load(8'h22, 0); load(8'h33, 0);
    wait_n(3);
    chk(req_n == 0, "R6 req asserted with unread data", req_n, 0);
    chk(sflag == 0, "R6 no flag while idle", sflag, 0);

    dir_out = 0;
    xip_n = 0;
    wait_n(2);
    chk(sflag == 0, "R12 not yet after two edges", sflag, 0);
    wait_n(1);
    chk(sflag == 1, "R12 flag on third edge", sflag, 1);
    chk(sr_q == 8'h11, "R4 first inbound byte", sr_q, 8'h11);
    host_read();
    chk(sflag == 0, "R9 read clears flag", sflag, 0);
    chk(sr_q == 8'h11, "R9 read keeps value", sr_q, 8'h11);
    ack_n = 0; wait_n(4);
    chk(sr_q == 8'h22, "R4 second inbound byte", sr_q, 8'h22);
    chk(req_n == 0, "R5 req held before last", req_n, 0);
    host_read();
    ack_n = 1; wait_n(4);
    chk(sr_q == 8'h33, "R4 last inbound byte", sr_q, 8'h33);
    chk(req_n == 1, "R5 req released after last", req_n, 1);
    host_read();
    ack_n = 0; wait_n(4);
    chk(sflag == 0, "R4 no load when drained", sflag, 0);
    chk(sr_q == 8'h33, "R4 sr unchanged when drained", sr_q, 8'h33);
    ack_n = 1; wait_n(4);
    xip_n = 1; wait_n(4);
    chk(sflag == 1, "R8 flag at end without packet", sflag, 1);
    chk(req_n == 1, "R5 req stays released", req_n, 1);
    host_read();

    dir_out = 1;
    host_write(8'h5A);
    exp_byte_q.push_back(8'h5A);
    xip_n = 0; wait_n(4);
    chk(sflag == 1, "R2 capture sets flag", sflag, 1);
    host_read();
    for (int k = 0; k < 3; k++) begin
      host_write(8'hB1 + 8'(k));
      exp_byte_q.push_back(8'hB1 + 8'(k));
      ack_n = ~ack_n; wait_n(4);
      chk(sflag == 1, "R2 capture sets flag", sflag, 1);
      host_read();
    end
    host_write(8'hB4);
    ack_n = ~ack_n; wait_n(4);
    chk(sflag == 0, "R3 overflow byte sets no flag", sflag, 0);
    ack_n = 1; wait_n(4);
    chk(sflag == 0, "R3 overflow edge ignored", sflag, 0);
    exp_len_q.push_back(4);
    xip_n = 1; wait_n(4);
    chk(sflag == 1, "R8 flag at packet end", sflag, 1);
    host_read();

    host_write(8'hC7);
    exp_byte_q.push_back(8'hC7);
    exp_len_q.push_back(1);
    xip_n = 0; wait_n(4);
    xip_n = 1; wait_n(4);
    chk(exp_len_q.size() == 0, "R8 count restarted, both packets seen", exp_len_q.size(), 0);
    host_read();

    chk(req_n == 1, "R7 req idle before sync", req_n, 1);
    ack_n = 0; wait_n(4);
    chk(req_n == 0, "R7 req echoes ack low", req_n, 0);
    chk(sflag == 1, "R7 sync toggle sets flag", sflag, 1);
    host_read();
    ack_n = 1; wait_n(4);
    chk(req_n == 1, "R7 req echoes ack high", req_n, 1);
    host_read();

    for (int k = 0; k < 7; k++) begin
      din[k] = 8'hD0 + 8'(k);
      load(din[k], k == 0);
    end
    wait_n(2);
    chk(req_n == 0, "R10 reload restarts read position", req_n, 0);
    dir_out = 0;
    xip_n = 0; wait_n(4);
    chk(sr_q == din[0], "R10 first reloaded byte", sr_q, din[0]);
    host_read();
    for (int k = 1; k < TIN; k++) begin
      ack_n = ~ack_n; wait_n(4);
      chk(sr_q == din[k], "R4 reloaded byte", sr_q, din[k]);
      host_read();
    end
    chk(req_n == 1, "R5 release after sixth byte", req_n, 1);
    ack_n = ~ack_n; wait_n(4);
    chk(sflag == 0, "R10 seventh byte was dropped", sflag, 0);
    chk(sr_q == din[TIN-1], "R10 sr keeps last byte", sr_q, din[TIN-1]);
    ack_n = 1; wait_n(4);
    xip_n = 1; wait_n(4);
    host_read();

    chk(exp_byte_q.size() == 0, "R2 all captured bytes compared", exp_byte_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule